// File: doc/BRIEF.md
# Logarithmic Number System Multiply/Divide/Square-Root Unit

This unit works on real numbers that are already held in logarithmic form. Each value has three parts: a zero flag, a sign bit, and a two's-complement fixed-point base-2 logarithm of its magnitude with 8 integer bits and 23 fraction bits. The value is (-1)^sign * 2^(log / 2^23). Operands arrive in this form, so the unit does no conversion on the way in or on the way out.

The three operations need only integer logic. A multiply adds the two logarithms. A divide subtracts them. A square root shifts the logarithm right by one bit. The sign of a product or quotient is the exclusive-OR of the operand signs. No multiplier array is used. The unit accepts one operation every cycle, together with a 2-bit opcode, and gives the result a fixed two cycles later. Zero operands, a zero divisor, the square root of a negative value, and a result whose logarithm falls outside the 31-bit range are each handled by a fixed rule and reported on an exception flag.

Top module: `lns_mul_unit`

## Requirements
- R1: Opcode 0 (multiply) with both operands non-zero gives log = aLog + bLog and sign = aSign XOR bSign.
- R2: Opcode 1 (divide) with both operands non-zero gives log = aLog - bLog and sign = aSign XOR bSign.
- R3: Opcode 2 (square root) uses operand a only. For a non-zero positive a it gives log = aLog arithmetically shifted right by one bit (rounding toward minus infinity) and sign 0. For a non-zero negative a it gives a zero result and sets invalidFlag.
- R4: A zero operand gives a zero result and raises no flag when no other exception applies. This covers a multiply with either operand zero, a divide with a zero dividend and a non-zero divisor, and a square root of zero, whatever the sign bits are.
- R5: Opcode 1 with a zero divisor sets divZeroFlag and gives a zero result, even when the dividend is also zero.
- R6: When the exact result log is above 2^30-1, resLog saturates to 2^30-1, resZero stays 0, the computed sign is kept, and ovfFlag is set.
- R7: When the exact result log is below -2^30, the result is zero and unfFlag is set. At most one of the four flags is set in any result.
- R8: An operation presented with inValid high in cycle t appears with outValid high after exactly two rising clock edges. A new operation can be accepted in every cycle.
- R9: Opcode 3 is reserved. It gives a zero result and sets invalidFlag.
- R10: After reset, and in every cycle where outValid is low, every output is 0.
- R11: A zero result always shows resZero=1, resSign=0 and resLog=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 multiply, 1 divide, 2 square root, 3 reserved |
| aZero | input | 1 | Operand a is zero |
| aSign | input | 1 | Operand a is negative |
| aLog | input | 31 | Operand a log, two's complement Q8.23 |
| bZero | input | 1 | Operand b is zero |
| bSign | input | 1 | Operand b is negative |
| bLog | input | 31 | Operand b log, two's complement Q8.23 |
| outValid | output | 1 | Result present this cycle |
| resZero | output | 1 | Result is zero |
| resSign | output | 1 | Result is negative |
| resLog | output | 31 | Result log, two's complement Q8.23 |
| ovfFlag | output | 1 | Log overflow, saturated |
| unfFlag | output | 1 | Log underflow, flushed to zero |
| divZeroFlag | output | 1 | Division by zero |
| invalidFlag | output | 1 | Negative square root or reserved opcode |

## Verification
A fault in the stage-one strobes or in the widened sum shows up at the ports exactly two edges after the operation that caused it. It appears as a wrong log or sign, a missing or extra flag, or a zero result that should not be zero. The bench therefore compares every output field of every vector in that cycle. Random operands over the full log range produce many overflows and underflows, and directed vectors place sums exactly on the saturation boundaries. A fault in the valid pipeline shows up as a result one cycle early or late, or as stray output during idle cycles. Random idle gaps in the input stream expose such a fault on the first gap.

// File: rtl/lns_mul_pkg.sv
`timescale 1ns/1ps
package lns_mul_pkg;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_DIV  = 2'd1,
    OP_SQRT = 2'd2,
    OP_RSV  = 2'd3
  } lnsOp_e;

  // Selection strobes used by the datapath in stage one
  typedef struct packed {
    logic opSub;
    logic opHalf;
  } lnsSel_t;

  // Registered control carried alongside stage one
  typedef struct packed {
    logic valid;
    logic forceZero;
    logic divZero;
    logic invalid;
    logic signOut;
  } lnsStage_t;

endpackage

// File: rtl/lns_mul_ctrl.sv
`timescale 1ns/1ps
module lns_mul_ctrl
  import lns_mul_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] op,
  input  logic      aZero,
  input  logic      aSign,
  input  logic      bZero,
  input  logic      bSign,
  output lnsSel_t   selNow,
  output lnsStage_t stageQ
);

  lnsOp_e    opCode;
  lnsStage_t stageD;

  assign opCode = lnsOp_e'(op);

  always_comb begin
    selNow         = '0;
    stageD         = '0;
    stageD.valid   = inValid;
    unique case (opCode)
      OP_MUL: begin
        stageD.forceZero = aZero | bZero;
        stageD.signOut   = aSign ^ bSign;
      end
      OP_DIV: begin
        selNow.opSub     = 1'b1;
        stageD.divZero   = bZero;
        stageD.forceZero = aZero | bZero;
        stageD.signOut   = aSign ^ bSign;
      end
      OP_SQRT: begin
        selNow.opHalf    = 1'b1;
        stageD.invalid   = ~aZero & aSign;
        stageD.forceZero = aZero | aSign;
      end
      default: begin
        stageD.invalid   = 1'b1;
        stageD.forceZero = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= stageD;
  end

  AST_STAGE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> stageQ.valid); // R8

  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !stageQ.valid); // R8

endmodule

// File: rtl/lns_mul_dpath.sv
`timescale 1ns/1ps
module lns_mul_dpath
  import lns_mul_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [INT_W+FRAC_W-1:0]  aLog,
  input  logic [INT_W+FRAC_W-1:0]  bLog,
  input  lnsSel_t                  selNow,
  input  lnsStage_t                stageQ,
  output logic                     outValid,
  output logic                     resZero,
  output logic                     resSign,
  output logic [INT_W+FRAC_W-1:0]  resLog,
  output logic                     ovfFlag,
  output logic                     unfFlag,
  output logic                     divZeroFlag,
  output logic                     invalidFlag
);

  localparam int LOG_W = INT_W + FRAC_W;
  localparam int EXT_W = LOG_W + 1;
  localparam logic [LOG_W-1:0] LOG_MAX = {1'b0, {(LOG_W-1){1'b1}}};

  logic [EXT_W-1:0] aExt, bExt, wideD, wideQ;
  logic [1:0]       rangeTop;

  assign aExt = {aLog[LOG_W-1], aLog};
  assign bExt = {bLog[LOG_W-1], bLog};

  // Stage one: integer add, subtract or halve on the widened log
  always_comb begin
    if (selNow.opHalf)     wideD = {aLog[LOG_W-1], aLog[LOG_W-1], aLog[LOG_W-1:1]};
    else if (selNow.opSub) wideD = aExt - bExt;
    else                   wideD = aExt + bExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wideQ <= '0;
    else       wideQ <= wideD;
  end

  assign rangeTop = wideQ[EXT_W-1:EXT_W-2];

  // Stage two: range check, saturation and exception flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; resZero <= 1'b0; resSign <= 1'b0; resLog <= '0;
      ovfFlag <= 1'b0; unfFlag <= 1'b0; divZeroFlag <= 1'b0; invalidFlag <= 1'b0;
    end else begin
      outValid <= stageQ.valid;
      resZero <= 1'b0; resSign <= 1'b0; resLog <= '0;
      ovfFlag <= 1'b0; unfFlag <= 1'b0; divZeroFlag <= 1'b0; invalidFlag <= 1'b0;
      if (stageQ.valid) begin
        if (stageQ.forceZero) begin
          resZero     <= 1'b1;
          divZeroFlag <= stageQ.divZero;
          invalidFlag <= stageQ.invalid;
        end else if (rangeTop == 2'b01) begin
          ovfFlag <= 1'b1;
          resSign <= stageQ.signOut;
          resLog  <= LOG_MAX;
        end else if (rangeTop == 2'b10) begin
          unfFlag <= 1'b1;
          resZero <= 1'b1;
        end else begin
          resSign <= stageQ.signOut;
          resLog  <= wideQ[LOG_W-1:0];
        end
      end
    end
  end

  AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    stageQ.valid |=> outValid); // R8

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resZero) |-> (!resSign && resLog == '0)); // R11

  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ovfFlag) |-> (resLog == LOG_MAX && !resZero)); // R6

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ovfFlag, unfFlag, divZeroFlag, invalidFlag})); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(resZero | resSign | ovfFlag | unfFlag | divZeroFlag | invalidFlag)); // R10

endmodule

// File: rtl/lns_mul_unit.sv
`timescale 1ns/1ps
module lns_mul_unit
  import lns_mul_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [1:0]              op,
  input  logic                    aZero,
  input  logic                    aSign,
  input  logic [INT_W+FRAC_W-1:0] aLog,
  input  logic                    bZero,
  input  logic                    bSign,
  input  logic [INT_W+FRAC_W-1:0] bLog,
  output logic                    outValid,
  output logic                    resZero,
  output logic                    resSign,
  output logic [INT_W+FRAC_W-1:0] resLog,
  output logic                    ovfFlag,
  output logic                    unfFlag,
  output logic                    divZeroFlag,
  output logic                    invalidFlag
);

  lnsSel_t   selNow;
  lnsStage_t stageQ;

  lns_mul_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
    .aZero(aZero), .aSign(aSign), .bZero(bZero), .bSign(bSign),
    .selNow(selNow), .stageQ(stageQ)
  );

  lns_mul_dpath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dpath_i (
    .clk(clk), .rstN(rstN), .aLog(aLog), .bLog(bLog),
    .selNow(selNow), .stageQ(stageQ),
    .outValid(outValid), .resZero(resZero), .resSign(resSign), .resLog(resLog),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .divZeroFlag(divZeroFlag),
    .invalidFlag(invalidFlag)
  );

endmodule

// File: tb/lns_mul_unit_tb_top.sv
`timescale 1ns/1ps
module lns_mul_unit_tb_top;

  localparam int LOG_W = 31;
  localparam logic [LOG_W-1:0] LMAX = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] LMIN = {1'b1, {(LOG_W-1){1'b0}}};

  typedef struct packed {
    logic v, z, s;
    logic [LOG_W-1:0] l;
    logic ovf, unf, dz, inv;
  } res_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] op = '0;
  logic aZero = 1'b0, aSign = 1'b0, bZero = 1'b0, bSign = 1'b0;
  logic [LOG_W-1:0] aLog = '0, bLog = '0;
  logic outValid, resZero, resSign, ovfFlag, unfFlag, divZeroFlag, invalidFlag;
  logic [LOG_W-1:0] resLog;

  int checks = 0;
  int fails  = 0;
  res_t exp1 = '0, exp2 = '0;
  string tag1 = "R10", tag2 = "R10";

  always #2.5 clk = ~clk;

  lns_mul_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
    .aZero(aZero), .aSign(aSign), .aLog(aLog),
    .bZero(bZero), .bSign(bSign), .bLog(bLog),
    .outValid(outValid), .resZero(resZero), .resSign(resSign), .resLog(resLog),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .divZeroFlag(divZeroFlag),
    .invalidFlag(invalidFlag)
  );

  function automatic res_t model(input logic iv, input logic [1:0] o,
      input logic az, input logic as, input logic [LOG_W-1:0] al,
      input logic bz, input logic bs, input logic [LOG_W-1:0] bl);
    res_t r = '0;
    logic signed [LOG_W:0] w;
    logic sg;
    logic zero = 1'b0;
    if (!iv) return r;                  // R10
    r.v = 1'b1;
    w = '0; sg = 1'b0;
    case (o)
      2'd0: begin zero = az | bz; sg = as ^ bs;
              w = $signed({al[LOG_W-1], al}) + $signed({bl[LOG_W-1], bl}); end
      2'd1: begin r.dz = bz; zero = az | bz; sg = as ^ bs;
              w = $signed({al[LOG_W-1], al}) - $signed({bl[LOG_W-1], bl}); end
      2'd2: begin r.inv = ~az & as; zero = az | as;
              w = $signed({al[LOG_W-1], al}) >>> 1; end
      default: begin r.inv = 1'b1; zero = 1'b1; end
    endcase
    if (zero) r.z = 1'b1;
    else if (w > $signed({LMAX[LOG_W-1], LMAX})) begin r.ovf = 1'b1; r.s = sg; r.l = LMAX; end
    else if (w < $signed({LMIN[LOG_W-1], LMIN})) begin r.unf = 1'b1; r.z = 1'b1; end
    else begin r.s = sg; r.l = w[LOG_W-1:0]; end
    return r;
  endfunction

  function automatic string tagOf(input logic [1:0] o, input res_t r);
    if (!r.v)        return "R10";
    if (r.ovf)       return "R6";
    if (r.unf)       return "R7,R11";
    if (r.dz)        return "R5,R11";
    if (o == 2'd3)   return "R9,R11";
    if (o == 2'd2)   return r.z ? (r.inv ? "R3,R11" : "R4,R11") : "R3";
    if (r.z)         return "R4,R11";
    return (o == 2'd0) ? "R1" : "R2";
  endfunction

  task automatic checkOut(input res_t e, input string t);
    res_t act;
    act = '{outValid, resZero, resSign, resLog, ovfFlag, unfFlag, divZeroFlag, invalidFlag};
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s/R8 act v%b z%b s%b l%h o%b u%b d%b i%b exp v%b z%b s%b l%h o%b u%b d%b i%b",
        t, act.v, act.z, act.s, act.l, act.ovf, act.unf, act.dz, act.inv,
        e.v, e.z, e.s, e.l, e.ovf, e.unf, e.dz, e.inv);
    end
  endtask

  // Drive at a falling edge; the result of this vector is checked two falling edges later (R8)
  task automatic applyVec(input logic iv, input logic [1:0] o,
      input logic az, input logic as, input logic [LOG_W-1:0] al,
      input logic bz, input logic bs, input logic [LOG_W-1:0] bl);
    res_t e;
    @(negedge clk);
    checkOut(exp2, tag2);
    inValid = iv; op = o; aZero = az; aSign = as; aLog = al;
    bZero = bz; bSign = bs; bLog = bl;
    e = model(iv, o, az, as, al, bz, bs, bl);
    exp2 = exp1; tag2 = tag1;
    exp1 = e;    tag1 = tagOf(o, e);
  endtask

  function automatic logic [LOG_W-1:0] rndLog();
    logic [LOG_W-1:0] x;
    x = LOG_W'($urandom);
    case ($urandom % 4)
      0: x = {2'b01, x[LOG_W-3:0]};
      1: x = {2'b10, x[LOG_W-3:0]};
      2: x = {{8{x[LOG_W-1]}}, x[LOG_W-9:0]};
      default: ;
    endcase
    return x;
  endfunction

  initial begin
    void'($urandom(32'h5eed_1a7e));
    repeat (3) @(negedge clk);
    checkOut('0, "R10");                                  // reset state
    rstN = 1'b1;
    // directed corners
    applyVec(1, 2'd0, 0, 0, 31'h0080_0000, 0, 1, 31'h0100_0000);  // R1: 2*-4
    applyVec(1, 2'd1, 0, 1, 31'h0180_0000, 0, 1, 31'h0080_0000);  // R2
    applyVec(1, 2'd2, 0, 0, 31'h0100_0000, 0, 0, '0);             // R3: sqrt 4
    applyVec(1, 2'd2, 0, 0, {LOG_W{1'b1}}, 0, 0, '0);             // R3: floor of -1 lsb
    applyVec(1, 2'd2, 0, 1, 31'h0100_0000, 0, 0, '0);             // R3: negative
    applyVec(1, 2'd2, 1, 1, 31'h0100_0000, 0, 0, '0);             // R4: sqrt of zero
    applyVec(1, 2'd0, 1, 1, 31'h0000_0005, 0, 1, 31'h0000_0007);  // R4
    applyVec(1, 2'd1, 1, 0, 31'h0000_0005, 0, 1, 31'h0000_0007);  // R4
    applyVec(1, 2'd1, 0, 0, 31'h0000_0005, 1, 0, '0);             // R5
    applyVec(1, 2'd1, 1, 0, '0, 1, 0, '0);                        // R5 both zero
    applyVec(1, 2'd0, 0, 1, LMAX, 0, 0, 31'h0000_0001);           // R6 just over
    applyVec(1, 2'd0, 0, 0, LMAX, 0, 0, '0);                      // R1 exactly max
    applyVec(1, 2'd0, 0, 0, LMIN, 0, 0, {LOG_W{1'b1}});           // R7 just under
    applyVec(1, 2'd1, 0, 0, LMIN, 0, 0, '0);                      // R2 exactly min
    applyVec(1, 2'd1, 0, 0, LMIN, 0, 1, 31'h0000_0001);           // R7
    applyVec(1, 2'd3, 0, 0, 31'h1, 0, 0, 31'h1);                  // R9
    applyVec(0, 2'd0, 0, 0, 31'h1, 0, 0, 31'h1);                  // R10 idle
    // random mix, back-to-back with idle gaps
    for (int i = 0; i < 600; i++) begin
      logic iv;
      iv = ($urandom % 8) != 0;
      applyVec(iv, 2'($urandom), ($urandom % 8) == 0, 1'($urandom), rndLog(),
               ($urandom % 8) == 0, 1'($urandom), rndLog());
    end
    applyVec(0, 2'd0, 0, 0, '0, 0, 0, '0);
    applyVec(0, 2'd0, 0, 0, '0, 0, 0, '0);
    applyVec(0, 2'd0, 0, 0, '0, 0, 0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 act hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule